// File: doc/BRIEF.md
# Inter-Processor Request Mailbox

This block lets a host processor hand command requests to an I/O processor and get completion notices back. The host stores the memory address of a request structure in the request pointer register and then rings a doorbell bit in a shared flag word. The I/O processor is interrupted by that doorbell. When it finishes the work, it places the completed request's address in the reply pointer register and sets a two-bit reply pattern in the flag word, which interrupts the host. The block carries only pointers and flags. It never looks at the structures those pointers address.

Each processor has its own write/read port and its own interrupt line. Both ports read through a combinational path, so a read returns the register's current contents in the same cycle. In the flag word each side owns some bits. A side can only set the bits it owns, and it clears the other side's bits by writing ones to them. When both ports write the flag word in the same edge, both requests are merged so that no update is lost.

Top module: `ipc_mailbox`

## Requirements
- R1: After reset both pointers, all flag bits and both interrupt outputs are zero.
- R2: A host write to address 0 loads the request pointer with bits [1:0] forced to zero. An I/O-port write to address 0 leaves the request pointer unchanged.
- R3: An I/O-port write to address 2 loads the reply pointer with bits [1:0] forced to zero. A host write to address 2 leaves the reply pointer unchanged.
- R4: A host write to address 1 sets flag bits 0 and 1 wherever the data has ones there, and clears flag bits 2 to 5 wherever the data has ones there. Zero data bits leave their flags unchanged.
- R5: An I/O-port write to address 1 sets flag bits 2 to 5 wherever the data has ones there, and clears flag bits 0 and 1 wherever the data has ones there.
- R6: `iop_irq` is high exactly while flag bit 0 (request ready) is set, and `host_irq` is high exactly while flag bit 4 is set. Both are valid from the cycle after the write edge.
- R7: When both ports write address 1 at the same edge, every set and every clear is applied. If a set and a clear meet on the same bit, the set wins.
- R8: Reads on either port are combinational. Address 1 returns the six flags in bits [5:0] with zeros above them. Address 3 always reads zero, and writes to it change no state.
- R9: An I/O-port write of 0x14 to address 1 sets flag bits 2 and 4 (the reply pattern) and raises `host_irq`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr_en | input | 1 | Host write strobe |
| host_addr | input | 2 | Host register select (0 request, 1 flags, 2 reply, 3 spare) |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data for host_addr |
| iop_wr_en | input | 1 | I/O-processor write strobe |
| iop_addr | input | 2 | I/O-processor register select |
| iop_wdata | input | 32 | I/O-processor write data |
| iop_rdata | output | 32 | I/O-processor read data for iop_addr |
| host_irq | output | 1 | Reply interrupt to the host (flag bit 4) |
| iop_irq | output | 1 | Request interrupt to the I/O processor (flag bit 0) |

## Verification
Each write is applied at the rising edge on which its strobe is seen. The changed pointer, flag or interrupt is visible one edge later, and read data follows the address with no clock at all. The bench drives its strobes on a falling edge, removes them on the next falling edge and checks the outputs at that moment, which is half a period after the edge that took the write. Reads are checked a short delay after the address changes, and no clock edge occurs in that interval.

// File: rtl/ipc_mbox_pkg.sv
package ipc_mbox_pkg;

   // Register select codes seen on both ports
   typedef enum logic [1:0] {
      MB_REQ_PTR   = 2'd0,
      MB_FLAGS     = 2'd1,
      MB_REPLY_PTR = 2'd2,
      MB_SPARE     = 2'd3
   } mb_sel_e;

   // Mask that zeroes the low align_bits of a pointer
   function automatic logic [63:0] mb_align_mask(input int unsigned align_bits);
      logic [63:0] low;
      low = (64'd1 << align_bits) - 64'd1;
      return ~low;
   endfunction

endpackage

// File: rtl/mbox_ptr_reg.sv
module mbox_ptr_reg
   import ipc_mbox_pkg::*;
#(
   parameter int unsigned PTR_W      = 32,
   parameter int unsigned ALIGN_BITS = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [PTR_W-1:0] wdata,
   output logic [PTR_W-1:0] q
);

   localparam logic [PTR_W-1:0] KEEP = PTR_W'(mb_align_mask(ALIGN_BITS));

   if (ALIGN_BITS >= PTR_W) begin : g_bad_align
      $error("mbox_ptr_reg: ALIGN_BITS must be below PTR_W");
   end

   // Forced-zero low bits are constant flops and are trimmed downstream
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (we) q <= wdata & KEEP;
   end

endmodule

// File: rtl/mbox_flag_reg.sv
module mbox_flag_reg #(
   parameter int unsigned HOST_BITS = 2,
   parameter int unsigned IOP_BITS  = 4,
   localparam int unsigned FLAG_W   = HOST_BITS + IOP_BITS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_we,
   input  logic [FLAG_W-1:0] host_bits,
   input  logic              iop_we,
   input  logic [FLAG_W-1:0] iop_bits,
   output logic [FLAG_W-1:0] q
);

   logic [FLAG_W-1:0] set_v;
   logic [FLAG_W-1:0] clr_v;

   // Each bit picks its owner: the owner's ones set it, the peer's ones clear it
   for (genvar i = 0; i < FLAG_W; i++) begin : g_bit
      if (i < HOST_BITS) begin : g_host_owned
         assign set_v[i] = host_we & host_bits[i];
         assign clr_v[i] = iop_we  & iop_bits[i];
      end else begin : g_iop_owned
         assign set_v[i] = iop_we  & iop_bits[i];
         assign clr_v[i] = host_we & host_bits[i];
      end
   end

   // Set dominates clear so a fresh doorbell is never dropped
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= (q & ~clr_v) | set_v;
   end

endmodule

// File: rtl/mbox_rd_mux.sv
module mbox_rd_mux
   import ipc_mbox_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned PTR_W  = 32,
   parameter int unsigned FLAG_W = 6
) (
   input  logic [1:0]        sel,
   input  logic [PTR_W-1:0]  req_ptr,
   input  logic [PTR_W-1:0]  rep_ptr,
   input  logic [FLAG_W-1:0] flags,
   output logic [DATA_W-1:0] rdata
);

   always_comb begin
      unique case (mb_sel_e'(sel))
         MB_REQ_PTR:   rdata = DATA_W'(req_ptr);
         MB_FLAGS:     rdata = DATA_W'(flags);
         MB_REPLY_PTR: rdata = DATA_W'(rep_ptr);
         default:      rdata = '0;
      endcase
   end

endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox
   import ipc_mbox_pkg::*;
#(
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned PTR_W      = 32,
   parameter int unsigned ALIGN_BITS = 2,
   parameter int unsigned HOST_BITS  = 2,
   parameter int unsigned IOP_BITS   = 4,
   parameter int unsigned REQ_BIT    = 0,
   parameter int unsigned REPLY_BIT  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_wr_en,
   input  logic [1:0]        host_addr,
   input  logic [DATA_W-1:0] host_wdata,
   output logic [DATA_W-1:0] host_rdata,
   input  logic              iop_wr_en,
   input  logic [1:0]        iop_addr,
   input  logic [DATA_W-1:0] iop_wdata,
   output logic [DATA_W-1:0] iop_rdata,
   output logic              host_irq,
   output logic              iop_irq
);

   localparam int unsigned FLAG_W = HOST_BITS + IOP_BITS;

   // Elaboration-time parameter checks
   if (PTR_W > DATA_W) begin : g_chk_ptr
      $error("ipc_mailbox: PTR_W exceeds DATA_W");
   end
   if (FLAG_W > DATA_W) begin : g_chk_flag
      $error("ipc_mailbox: flag word wider than data bus");
   end
   if (REQ_BIT >= HOST_BITS) begin : g_chk_req
      $error("ipc_mailbox: REQ_BIT must be a host-owned flag");
   end
   if (REPLY_BIT < HOST_BITS || REPLY_BIT >= FLAG_W) begin : g_chk_rep
      $error("ipc_mailbox: REPLY_BIT must be an I/O-owned flag");
   end

   logic [PTR_W-1:0]  req_ptr;
   logic [PTR_W-1:0]  rep_ptr;
   logic [FLAG_W-1:0] flag_q;

   // Port-specific write decode: each pointer has one writer only
   logic req_we, rep_we, host_flag_we, iop_flag_we;
   assign req_we       = host_wr_en && (mb_sel_e'(host_addr) == MB_REQ_PTR);
   assign rep_we       = iop_wr_en  && (mb_sel_e'(iop_addr)  == MB_REPLY_PTR);
   assign host_flag_we = host_wr_en && (mb_sel_e'(host_addr) == MB_FLAGS);
   assign iop_flag_we  = iop_wr_en  && (mb_sel_e'(iop_addr)  == MB_FLAGS);

   mbox_ptr_reg #(.PTR_W(PTR_W), .ALIGN_BITS(ALIGN_BITS)) u_req (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (req_we),
      .wdata (host_wdata[PTR_W-1:0]),
      .q     (req_ptr)
   );

   mbox_ptr_reg #(.PTR_W(PTR_W), .ALIGN_BITS(ALIGN_BITS)) u_rep (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (rep_we),
      .wdata (iop_wdata[PTR_W-1:0]),
      .q     (rep_ptr)
   );

   mbox_flag_reg #(.HOST_BITS(HOST_BITS), .IOP_BITS(IOP_BITS)) u_flags (
      .clk       (clk),
      .rst_n     (rst_n),
      .host_we   (host_flag_we),
      .host_bits (host_wdata[FLAG_W-1:0]),
      .iop_we    (iop_flag_we),
      .iop_bits  (iop_wdata[FLAG_W-1:0]),
      .q         (flag_q)
   );

   // One read mux per port
   mbox_rd_mux #(.DATA_W(DATA_W), .PTR_W(PTR_W), .FLAG_W(FLAG_W)) u_host_rd (
      .sel     (host_addr),
      .req_ptr (req_ptr),
      .rep_ptr (rep_ptr),
      .flags   (flag_q),
      .rdata   (host_rdata)
   );

   mbox_rd_mux #(.DATA_W(DATA_W), .PTR_W(PTR_W), .FLAG_W(FLAG_W)) u_iop_rd (
      .sel     (iop_addr),
      .req_ptr (req_ptr),
      .rep_ptr (rep_ptr),
      .flags   (flag_q),
      .rdata   (iop_rdata)
   );

   // Interrupts come straight from stored flags, no extra stage
   assign iop_irq  = flag_q[REQ_BIT];
   assign host_irq = flag_q[REPLY_BIT];

endmodule

// File: rtl/mbox_checker.sv
module mbox_checker
   import ipc_mbox_pkg::*;
#(
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned PTR_W      = 32,
   parameter int unsigned ALIGN_BITS = 2,
   parameter int unsigned FLAG_W     = 6,
   parameter int unsigned REQ_BIT    = 0,
   parameter int unsigned REPLY_BIT  = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              host_wr_en,
   input logic [1:0]        host_addr,
   input logic [DATA_W-1:0] host_wdata,
   input logic              iop_wr_en,
   input logic [1:0]        iop_addr,
   input logic [DATA_W-1:0] iop_wdata,
   input logic              host_irq,
   input logic              iop_irq,
   input logic [PTR_W-1:0]  req_q,
   input logic [PTR_W-1:0]  rep_q,
   input logic [FLAG_W-1:0] flag_q
);

   localparam logic [PTR_W-1:0] KEEP = PTR_W'(mb_align_mask(ALIGN_BITS));

   // R2: host write loads the aligned request pointer
   a_r2_req_load: assert property (@(posedge clk) disable iff (!rst_n)
      (host_wr_en && host_addr == 2'd0) |=> req_q == ($past(host_wdata[PTR_W-1:0]) & KEEP));

   // R2: nothing else moves the request pointer
   a_r2_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(host_wr_en && host_addr == 2'd0) |=> $stable(req_q));

   // R3: I/O-port write loads the aligned reply pointer
   a_r3_rep_load: assert property (@(posedge clk) disable iff (!rst_n)
      (iop_wr_en && iop_addr == 2'd2) |=> rep_q == ($past(iop_wdata[PTR_W-1:0]) & KEEP));

   // R3: nothing else moves the reply pointer
   a_r3_rep_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(iop_wr_en && iop_addr == 2'd2) |=> $stable(rep_q));

   // R4: flags only change on a flag-word write
   a_r4_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !((host_wr_en && host_addr == 2'd1) || (iop_wr_en && iop_addr == 2'd1))
      |=> $stable(flag_q));

   // R6: request interrupt only rises after a host doorbell
   a_r6_iop_irq_rise: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(iop_irq) |-> $past(host_wr_en && host_addr == 2'd1 && host_wdata[REQ_BIT]));

   // R6: reply interrupt only rises after an I/O-side reply flag write
   a_r6_host_irq_rise: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(host_irq) |-> $past(iop_wr_en && iop_addr == 2'd1 && iop_wdata[REPLY_BIT]));

   // R7: a host doorbell set survives any concurrent clear
   a_r7_host_set_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (host_wr_en && host_addr == 2'd1 && host_wdata[REQ_BIT]) |=> flag_q[REQ_BIT]);

   // R7: an I/O reply set survives any concurrent clear
   a_r7_iop_set_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (iop_wr_en && iop_addr == 2'd1 && iop_wdata[REPLY_BIT]) |=> flag_q[REPLY_BIT]);

endmodule

bind ipc_mailbox mbox_checker #(
   .DATA_W     (DATA_W),
   .PTR_W      (PTR_W),
   .ALIGN_BITS (ALIGN_BITS),
   .FLAG_W     (HOST_BITS + IOP_BITS),
   .REQ_BIT    (REQ_BIT),
   .REPLY_BIT  (REPLY_BIT)
) u_mbox_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .host_wr_en (host_wr_en),
   .host_addr  (host_addr),
   .host_wdata (host_wdata),
   .iop_wr_en  (iop_wr_en),
   .iop_addr   (iop_addr),
   .iop_wdata  (iop_wdata),
   .host_irq   (host_irq),
   .iop_irq    (iop_irq),
   .req_q      (req_ptr),
   .rep_q      (rep_ptr),
   .flag_q     (flag_q)
);

// File: tb/tb_ipc_mailbox.sv
`timescale 1ns/1ps
module tb_ipc_mailbox;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_wr_en = 1'b0;
   logic [1:0]  host_addr = 2'd0;
   logic [31:0] host_wdata = '0;
   logic [31:0] host_rdata;
   logic        iop_wr_en = 1'b0;
   logic [1:0]  iop_addr = 2'd0;
   logic [31:0] iop_wdata = '0;
   logic [31:0] iop_rdata;
   logic        host_irq;
   logic        iop_irq;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   ipc_mailbox dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .host_wr_en (host_wr_en),
      .host_addr  (host_addr),
      .host_wdata (host_wdata),
      .host_rdata (host_rdata),
      .iop_wr_en  (iop_wr_en),
      .iop_addr   (iop_addr),
      .iop_wdata  (iop_wdata),
      .iop_rdata  (iop_rdata),
      .host_irq   (host_irq),
      .iop_irq    (iop_irq)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   // Drive writes on a falling edge; they land at the next rising edge
   task automatic wr(input bit h_en, input logic [1:0] h_a, input logic [31:0] h_d,
                     input bit i_en, input logic [1:0] i_a, input logic [31:0] i_d);
      @(negedge clk);
      host_wr_en = h_en; host_addr = h_a; host_wdata = h_d;
      iop_wr_en  = i_en; iop_addr  = i_a; iop_wdata  = i_d;
      @(negedge clk);
      host_wr_en = 1'b0; iop_wr_en = 1'b0;
   endtask

   task automatic rd_host(input logic [1:0] a, output logic [31:0] d);
      host_addr = a; #1; d = host_rdata;
   endtask

   task automatic rd_iop(input logic [1:0] a, output logic [31:0] d);
      iop_addr = a; #1; d = iop_rdata;
   endtask

   task automatic t_reset;
      logic [31:0] d;
      for (int a = 0; a < 4; a++) begin
         rd_host(2'(a), d); check("R1 host read after reset", d, 32'h0);
         rd_iop(2'(a), d);  check("R1 iop read after reset", d, 32'h0);
      end
      check("R1 host_irq after reset", {31'd0, host_irq}, 32'h0);
      check("R1 iop_irq after reset", {31'd0, iop_irq}, 32'h0);
   endtask

   task automatic t_req_ptr;
      logic [31:0] d;
      wr(1, 2'd0, 32'h1234_5677, 0, 2'd0, 32'h0);
      rd_host(2'd0, d); check("R2 request pointer aligned (host)", d, 32'h1234_5674);
      rd_iop(2'd0, d);  check("R2 R8 request pointer (iop port)", d, 32'h1234_5674);
      wr(0, 2'd0, 32'h0, 1, 2'd0, 32'hDEAD_0000);
      rd_host(2'd0, d); check("R2 iop write to request ignored", d, 32'h1234_5674);
   endtask

   task automatic t_rep_ptr;
      logic [31:0] d;
      wr(0, 2'd0, 32'h0, 1, 2'd2, 32'h0ABC_DEF3);
      rd_host(2'd2, d); check("R3 reply pointer aligned", d, 32'h0ABC_DEF0);
      wr(1, 2'd2, 32'h5555_5555, 0, 2'd0, 32'h0);
      rd_iop(2'd2, d);  check("R3 host write to reply ignored", d, 32'h0ABC_DEF0);
   endtask

   task automatic t_host_flags;
      logic [31:0] d;
      wr(1, 2'd1, 32'h1, 0, 2'd0, 32'h0);
      rd_host(2'd1, d); check("R4 host sets bit 0", d, 32'h01);
      check("R6 iop_irq follows bit 0", {31'd0, iop_irq}, 32'h1);
      wr(1, 2'd1, 32'h2, 0, 2'd0, 32'h0);
      rd_host(2'd1, d); check("R4 zero bits keep flags", d, 32'h03);
      wr(0, 2'd0, 32'h0, 1, 2'd1, 32'h3C);
      rd_host(2'd1, d); check("R5 iop sets bits 2-5", d, 32'h3F);
      check("R6 host_irq follows bit 4", {31'd0, host_irq}, 32'h1);
      wr(1, 2'd1, 32'h14, 0, 2'd0, 32'h0);
      rd_host(2'd1, d); check("R4 host clears bits 2 and 4", d, 32'h2B);
      check("R6 host_irq drops with bit 4", {31'd0, host_irq}, 32'h0);
      wr(1, 2'd1, 32'hFFFF_FFC0, 0, 2'd0, 32'h0);
      rd_iop(2'd1, d);  check("R8 upper bits ignored and read zero", d, 32'h2B);
   endtask

   task automatic t_iop_flags;
      logic [31:0] d;
      wr(0, 2'd0, 32'h0, 1, 2'd1, 32'h03);
      rd_host(2'd1, d); check("R5 iop clears bits 0 and 1", d, 32'h28);
      check("R6 iop_irq drops with bit 0", {31'd0, iop_irq}, 32'h0);
      wr(0, 2'd0, 32'h0, 1, 2'd1, 32'h14);
      rd_host(2'd1, d); check("R9 reply pattern sets bits 2 and 4", d, 32'h3C);
      check("R9 host_irq raised by reply", {31'd0, host_irq}, 32'h1);
      wr(1, 2'd1, 32'h3C, 0, 2'd0, 32'h0);
      rd_host(2'd1, d); check("R4 host clears all I/O flags", d, 32'h00);
   endtask

   task automatic t_collision;
      logic [31:0] d;
      wr(1, 2'd1, 32'h01, 1, 2'd1, 32'h14);
      rd_host(2'd1, d); check("R7 both sets applied", d, 32'h15);
      wr(1, 2'd1, 32'h02, 1, 2'd1, 32'h01);
      rd_host(2'd1, d); check("R7 set and clear on different bits", d, 32'h16);
      wr(1, 2'd1, 32'h01, 1, 2'd1, 32'h01);
      rd_host(2'd1, d); check("R7 host set wins over iop clear", d, 32'h17);
      wr(1, 2'd1, 32'h10, 1, 2'd1, 32'h10);
      rd_host(2'd1, d); check("R7 iop set wins over host clear", d, 32'h17);
      wr(1, 2'd1, 32'h04, 1, 2'd1, 32'h08);
      rd_host(2'd1, d); check("R7 clear bit 2 with set bit 3", d, 32'h1B);
   endtask

   task automatic t_spare;
      logic [31:0] d;
      wr(1, 2'd3, 32'hFFFF_FFFF, 1, 2'd3, 32'hFFFF_FFFF);
      rd_host(2'd3, d); check("R8 spare reads zero", d, 32'h0);
      rd_host(2'd0, d); check("R8 spare write leaves request", d, 32'h1234_5674);
      rd_host(2'd2, d); check("R8 spare write leaves reply", d, 32'h0ABC_DEF0);
      rd_iop(2'd1, d);  check("R8 spare write leaves flags", d, 32'h1B);
   endtask

   initial begin
      #20000;
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_req_ptr();
      t_rep_ptr();
      t_host_flags();
      t_iop_flags();
      t_collision();
      t_spare();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule